// File: doc/BRIEF.md
# Display Refresh Timing Generator

This block produces the display-clock enable and the refresh sequencing for a multiplexed LED matrix driver. The display clock comes from one of two sources. The first is an on-chip oscillator, modelled as a divided copy of the system clock. The second is an external oscillator pin, which is synchronized into the system clock domain and reduced to one event per rising edge. On the external path only, an optional divide-by-8 prescaler can sit between the pin and the display clock.

Each display-clock event advances a 9-bit refresh position. One full frame is 512 display clocks. The block flags the start of every frame and the start of every 32-clock segment, which downstream scan logic uses as a row or column strobe. The internal oscillator is also driven out on a pin, so several devices can share one timebase: a master device drives the pin, and slave devices select their external source and take the master's oscillator from it.

A sleep input stops the oscillator and blanks everything. On wake, the prescaler and the refresh position restart from zero. Drive outputs stay inactive until the display clock is actually running again.

Top module: `disp_refresh_timer`

## Requirements
- R1: While reset is asserted, dclk_en, frame_start, seg_start, drive_en, osc_out and refresh_pos are all zero.
- R2: With src_ext=0, dclk_en pulses once per internal oscillator period, which is 2*INT_HALF system clocks. osc_out is a square wave with that period and a 50% duty cycle.
- R3: With src_ext=1 and prescale=0, dclk_en pulses once for every rising edge of ext_osc.
- R4: With src_ext=1 and prescale=1, dclk_en pulses once for every 8 rising edges of ext_osc.
- R5: With src_ext=0, the prescale input has no effect on the dclk_en rate.
- R6: refresh_pos advances by exactly one on each dclk_en pulse and is otherwise unchanged. It wraps from 511 to 0. frame_start is a one-cycle pulse that coincides with the dclk_en pulse on which refresh_pos becomes 0.
- R7: While sleep=1, osc_out, dclk_en and drive_en are low and refresh_pos is 0. After sleep falls, the first dclk_en in divide-by-8 mode comes on the 8th ext_osc rising edge.
- R8: A change of prescale takes effect only at a prescaler terminal count. In external mode, every interval between dclk_en pulses is therefore exactly one or exactly eight ext_osc periods, and never a shortened one.
- R9: drive_en is high exactly when sleep=0 and at least one dclk_en pulse has occurred since reset or since the last sleep.
- R10: seg_start is a one-cycle pulse that coincides with every dclk_en pulse on which the low 5 bits of refresh_pos become 0, and with no other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Stop oscillator, blank outputs, restart sequencing on release |
| src_ext | input | 1 | 0 selects the internal oscillator, 1 selects ext_osc |
| prescale | input | 1 | 1 divides the external source by 8 |
| ext_osc | input | 1 | External or master oscillator input (asynchronous) |
| dclk_en | output | 1 | One-cycle display-clock enable |
| frame_start | output | 1 | Pulse at refresh wrap to position 0 |
| seg_start | output | 1 | Pulse at each 32-clock segment boundary |
| refresh_pos | output | 9 | Current refresh position |
| drive_en | output | 1 | Pixel drive permitted |
| osc_out | output | 1 | Internal oscillator for slave devices |

## Verification
The embedded properties check the following on every cycle: refresh_pos stepping by one on each enable and holding otherwise, frame and segment pulses landing only on the matching position, the internal oscillator toggling after each tick, and the quiet state during sleep. Some behaviours only the directed scenarios can show. These are the rates measured against a counted number of ext_osc edges or internal periods, the fact that prescale is ignored on the internal path, the restart of the divide-by-8 count on wake, and the absence of shortened intervals when prescale flips in the middle of a count.

// File: rtl/disp_refresh_pkg.sv
package disp_refresh_pkg;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } src_sel_e;

    localparam int unsigned DEF_PRE_DIV = 8;

endpackage

// File: rtl/drt_clock_src.sv
module drt_clock_src
    import disp_refresh_pkg::*;
#(
    parameter int unsigned INT_HALF = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sleep,
    input  src_sel_e sel,
    input  logic     ext_osc,
    output logic     src_tick,
    output logic     osc_out
);
    localparam int unsigned CW = (INT_HALF > 2) ? $clog2(INT_HALF) : 1;
    localparam logic [CW-1:0] HALF_LAST = CW'(INT_HALF - 1);

    typedef struct packed {
        logic [CW-1:0] int_cnt;
        logic          osc;
        logic          sync1;
        logic          sync2;
        logic          prev;
    } src_state_t;

    src_state_t st_d, st_q;
    logic       int_tick;
    logic       ext_rise;

    always_comb begin
        st_d = st_q;
        if (sleep) begin
            st_d = '0;
        end else begin
            st_d.sync1 = ext_osc;
            st_d.sync2 = st_q.sync1;
            st_d.prev  = st_q.sync2;
            if (st_q.int_cnt == HALF_LAST) begin
                st_d.int_cnt = '0;
                st_d.osc     = ~st_q.osc;
            end else begin
                st_d.int_cnt = st_q.int_cnt + 1'b1;
            end
        end
        int_tick = !sleep && (st_q.int_cnt == HALF_LAST) && !st_q.osc;
        ext_rise = !sleep && st_q.sync2 && !st_q.prev;
        src_tick = (sel == SRC_EXT) ? ext_rise : int_tick;
        osc_out  = st_q.osc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the oscillator is high right after each internal tick
    p_int_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int_tick |=> osc_out);

endmodule

// File: rtl/drt_prescaler.sv
module drt_prescaler #(
    parameter int unsigned DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  logic use_ext,
    input  logic prescale,
    input  logic src_tick,
    output logic disp_tick
);
    localparam int unsigned CW = $clog2(DIV);
    localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          act;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       dividing;
    logic       terminal;

    always_comb begin
        st_d     = st_q;
        dividing = st_q.act && use_ext;
        terminal = !dividing || (st_q.cnt == CNT_LAST);
        if (sleep) begin
            st_d.cnt = '0;
            st_d.act = prescale;
        end else if (src_tick) begin
            if (terminal) begin
                st_d.cnt = '0;
                st_d.act = prescale;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        disp_tick = !sleep && src_tick && terminal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: the divide mode only changes right after a terminal count
    p_mode_at_terminal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sleep) && (st_q.act != $past(st_q.act))) |-> $past(disp_tick));

endmodule

// File: rtl/drt_refresh.sv
module drt_refresh #(
    parameter int unsigned POS_W = 9,
    parameter int unsigned SEG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             disp_tick,
    output logic             tick_out,
    output logic             frame_out,
    output logic             seg_out,
    output logic             started,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] POS_LAST = {POS_W{1'b1}};

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             tick;
        logic             frame;
        logic             seg;
        logic             started;
    } ref_state_t;

    ref_state_t       st_d, st_q;
    logic [POS_W-1:0] pos_next;

    always_comb begin
        st_d     = st_q;
        pos_next = st_q.pos + 1'b1;
        if (sleep) begin
            st_d = '0;
        end else begin
            st_d.tick  = disp_tick;
            st_d.frame = disp_tick && (st_q.pos == POS_LAST);
            st_d.seg   = disp_tick && (pos_next[SEG_W-1:0] == '0);
            if (disp_tick) begin
                st_d.pos     = pos_next;
                st_d.started = 1'b1;
            end
        end
        tick_out  = st_q.tick;
        frame_out = st_q.frame;
        seg_out   = st_q.seg;
        started   = st_q.started;
        pos       = st_q.pos;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: one step per enable
    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |-> st_q.pos == $past(st_q.pos) + 1'b1);
    // R6: position holds between enables
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.tick && !$past(sleep)) |-> $stable(st_q.pos));
    // R6: frame pulse only at the wrap
    p_frame_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.frame |-> (st_q.tick && st_q.pos == '0 && $past(st_q.pos) == POS_LAST));
    // R10: segment pulse only at a segment boundary
    p_seg_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seg |-> (st_q.tick && st_q.pos[SEG_W-1:0] == '0));

endmodule

// File: rtl/disp_refresh_timer.sv
module disp_refresh_timer
    import disp_refresh_pkg::*;
#(
    parameter int unsigned INT_HALF = 4,
    parameter int unsigned PRE_DIV  = DEF_PRE_DIV,
    parameter int unsigned POS_W    = 9,
    parameter int unsigned SEG_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             src_ext,
    input  logic             prescale,
    input  logic             ext_osc,
    output logic             dclk_en,
    output logic             frame_start,
    output logic             seg_start,
    output logic [POS_W-1:0] refresh_pos,
    output logic             drive_en,
    output logic             osc_out
);
    src_sel_e sel;
    logic     src_tick;
    logic     disp_tick;
    logic     started;

    assign sel = src_sel_e'(src_ext);

    drt_clock_src #(.INT_HALF(INT_HALF)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep    (sleep),
        .sel      (sel),
        .ext_osc  (ext_osc),
        .src_tick (src_tick),
        .osc_out  (osc_out)
    );

    drt_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep     (sleep),
        .use_ext   (sel == SRC_EXT),
        .prescale  (prescale),
        .src_tick  (src_tick),
        .disp_tick (disp_tick)
    );

    drt_refresh #(.POS_W(POS_W), .SEG_W(SEG_W)) u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep     (sleep),
        .disp_tick (disp_tick),
        .tick_out  (dclk_en),
        .frame_out (frame_start),
        .seg_out   (seg_start),
        .started   (started),
        .pos       (refresh_pos)
    );

    assign drive_en = started && !sleep;

    // R7: quiet while asleep
    p_sleep_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && $past(sleep)) |-> (!dclk_en && !osc_out && !drive_en && refresh_pos == '0));
    // R9: drive only after the display clock has run since wake
    p_drive_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> (dclk_en || $past(sleep)));

endmodule

// File: tb/disp_refresh_timer_tb.sv
module disp_refresh_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep = 1'b0;
    logic       src_ext = 1'b0;
    logic       prescale = 1'b0;
    logic       ext_osc = 1'b0;
    logic       dclk_en, frame_start, seg_start, drive_en, osc_out;
    logic [8:0] refresh_pos;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // monitor state
    int  cyc = 0;
    int  ticks = 0;
    int  frames = 0;
    int  osc_high = 0;
    int  exp_pos = 0;
    bit  exp_started = 1'b0;
    int  pos_err = 0, frame_err = 0, seg_err = 0, drive_err = 0;
    bit  osc_in_sleep = 1'b0;
    bit  mon_on = 1'b0;
    bit  iv_en = 1'b0;
    bit  have_last = 1'b0;
    int  last_t = 0, iv_bad = 0, iv_long = 0;

    always #2.5 clk = ~clk;

    disp_refresh_timer u_dut (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .src_ext(src_ext),
        .prescale(prescale), .ext_osc(ext_osc), .dclk_en(dclk_en),
        .frame_start(frame_start), .seg_start(seg_start),
        .refresh_pos(refresh_pos), .drive_en(drive_en), .osc_out(osc_out)
    );

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic check_near(input string req, input int act, input int exp_v, input int tol);
        checks++;
        if (act < exp_v - tol || act > exp_v + tol) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d+-%0d", req, act, exp_v, tol);
        end
    endtask

    // sampled 1 ns after each rising edge
    always begin
        @(posedge clk);
        #1;
        cyc++;
        if (mon_on) begin
            if (dclk_en) ticks++;
            if (osc_out) osc_high++;
            if (sleep && osc_out) osc_in_sleep = 1'b1;
            if (sleep) begin
                exp_pos = 0;
                exp_started = 1'b0;
            end else if (dclk_en) begin
                exp_pos = (exp_pos + 1) % 512;
                exp_started = 1'b1;
            end
            if (refresh_pos != exp_pos[8:0]) pos_err++;
            if (drive_en != (exp_started && !sleep)) drive_err++;
            if (frame_start) begin
                frames++;
                if (exp_pos != 0 || !dclk_en) frame_err++;
            end
            if (seg_start != (dclk_en && (exp_pos % 32 == 0))) seg_err++;
            if (iv_en && dclk_en) begin
                if (have_last) begin
                    if (cyc - last_t != 10 && cyc - last_t != 80) iv_bad++;
                    if (cyc - last_t == 80) iv_long++;
                end
                last_t = cyc;
                have_last = 1'b1;
            end
        end
    end

    task automatic ext_periods(input int n);
        for (int i = 0; i < n; i++) begin
            ext_osc = 1'b1;
            repeat (5) @(negedge clk);
            ext_osc = 1'b0;
            repeat (5) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 outputs in reset",
              int'({dclk_en, frame_start, seg_start, drive_en, osc_out}) + int'(refresh_pos), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
    endtask

    task automatic t_internal();
        int t0, h0;
        src_ext = 1'b0; prescale = 1'b0;
        repeat (20) @(negedge clk);
        t0 = ticks; h0 = osc_high;
        repeat (800) @(negedge clk);
        check_near("R2 internal tick rate", ticks - t0, 100, 1);
        check_near("R2 osc_out duty", osc_high - h0, 400, 4);
    endtask

    task automatic t_int_prescale();
        int t0;
        prescale = 1'b1;
        repeat (20) @(negedge clk);
        t0 = ticks;
        repeat (800) @(negedge clk);
        check_near("R5 prescale ignored on internal path", ticks - t0, 100, 1);
        prescale = 1'b0;
    endtask

    task automatic t_frames();
        int f0, t0;
        sleep = 1'b1;
        repeat (4) @(negedge clk);
        sleep = 1'b0;
        f0 = frames; t0 = ticks;
        repeat (8200) @(negedge clk);
        check_near("R6 ticks over two frames", ticks - t0, 1025, 1);
        check("R6 frame count after wake", frames - f0, 2);
        check("R6 frame pulse at wrap", frame_err, 0);
        check("R10 segment strobes", seg_err, 0);
    endtask

    task automatic t_ext_direct();
        int t0;
        src_ext = 1'b1; prescale = 1'b0;
        ext_periods(3);
        t0 = ticks;
        ext_periods(50);
        check_near("R3 one tick per external edge", ticks - t0, 50, 1);
    endtask

    task automatic t_ext_div();
        int t0;
        prescale = 1'b1;
        ext_periods(3);
        t0 = ticks;
        ext_periods(80);
        check_near("R4 divide by 8", ticks - t0, 10, 1);
    endtask

    task automatic t_sleep();
        int t0;
        sleep = 1'b1;
        t0 = ticks;
        ext_periods(20);
        check("R7 no ticks asleep", ticks - t0, 0);
        check("R7 osc_out low asleep", int'(osc_in_sleep), 0);
        check("R9 drive_en low asleep", int'(drive_en), 0);
        check("R7 position zero asleep", int'(refresh_pos), 0);
        sleep = 1'b0;
        t0 = ticks;
        ext_periods(7);
        check("R7 no tick before 8th edge after wake", ticks - t0, 0);
        check("R9 drive_en low before first tick", int'(drive_en), 0);
        ext_periods(1);
        check("R7 first tick on 8th edge after wake", ticks - t0, 1);
        check("R9 drive_en high once running", int'(drive_en), 1);
    endtask

    task automatic t_switch();
        prescale = 1'b0;
        ext_periods(2);
        have_last = 1'b0; iv_bad = 0; iv_long = 0;
        iv_en = 1'b1;
        ext_periods(20);
        prescale = 1'b1;
        ext_periods(43);
        prescale = 1'b0;
        ext_periods(30);
        iv_en = 1'b0;
        check("R8 no shortened interval", iv_bad, 0);
        check_near("R8 long intervals seen", iv_long, 5, 1);
    endtask

    initial begin
        t_reset();
        t_internal();
        t_int_prescale();
        t_frames();
        t_ext_direct();
        t_ext_div();
        t_sleep();
        t_switch();
        check("R6 position tracks enables", pos_err, 0);
        check("R9 drive_en tracking", drive_err, 0);
        check("R10 segment strobes overall", seg_err, 0);
        check("R6 frame pulses overall", frame_err, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule